// File: doc/BRIEF.md
# Asynchronous Parallel ROM Read Sequencer

This block sits on the clocked side of a chip and reads an external asynchronous parallel ROM that can return either 16-bit words or single bytes. A host presents a byte address together with a mode bit. The sequencer launches the address and the chip select, then opens the ROM's output drivers one cycle later. It counts clock cycles until every access window the ROM needs has run out, latches the data bus, and hands the result back with a one-cycle valid strobe. Once the data is latched it closes the output drivers. It does not accept another access until the ROM's outputs have had time to float and the minimum read-cycle time has passed.

All timing is given in picoseconds through parameters, along with the clock period. Each window becomes a cycle count, rounded up. The ROM needs three windows: address-to-data, select-to-data and output-enable-to-data. The sample point is the latest of these three, measured from the cycle in which the address is launched. In byte mode the ROM pin that otherwise carries data bit 15 becomes the lowest address bit, so the sequencer drives that pin and keeps only the low data byte. An optional mode leaves the chip select asserted between reads that follow each other directly, so the select window no longer sets the sample point for the second read.

Top module: `rom_rd_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rom_ce_n and rom_oe_n are 1, rsp_valid is 0 and rom_byte_n is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. In the cycle after that edge, rom_addr equals req_addr[ADDR_W:1], rom_ce_n is 0 and rom_oe_n is still 1. rom_oe_n falls one cycle later and rom_addr holds while rom_oe_n is 0.
- R3: In byte mode (req_byte=1), rom_byte_n is 0, rom_lsb_oe is 1 and rom_lsb_out carries req_addr[0]. The response is {8'h00, rom_d_in[7:0]}.
- R4: In word mode (req_byte=0), rom_byte_n is 1 and rom_lsb_oe is 0. req_addr[0] is ignored and the response is rom_d_in[15:0].
- R5: For a read that starts with the chip select released, the bus is latched on the edge S clock edges after the accept edge, with S = max(ceil(T_AA/CLK), ceil(T_ACE/CLK), 1+ceil(T_OE/CLK), 3). rsp_valid is 1 for exactly the one cycle after that edge.
- R6: rom_oe_n returns to 1 on the same edge that latches the data.
- R7: req_ready stays 0 from the accept edge until the cycle before edge G, counted from the accept edge, with G = max(ceil(T_RC/CLK), S+ceil(T_FLT/CLK)). The next accept is therefore never earlier than G edges after the previous one.
- R8: A request held during recovery is stalled with req_ready at 0 and is accepted on edge G.
- R9: With KEEP_CE=1, rom_ce_n stays 0 through recovery. A request accepted on edge G then uses S = max(ceil(T_AA/CLK), 1+ceil(T_OE/CLK), 3).
- R10: If no request is present at edge G, the block returns to idle: rom_ce_n becomes 1 and req_ready becomes 1.
- R11: rom_oe_n is never 0 while rom_ce_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W+1 | Byte address of the read |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | One-cycle strobe marking rsp_data |
| rsp_data | output | 16 | Captured read data |
| rom_addr | output | ADDR_W | Word address lines to the ROM |
| rom_lsb_out | output | 1 | Low address bit for the shared data/address pin |
| rom_lsb_oe | output | 1 | Drive enable of the shared pin (byte mode) |
| rom_byte_n | output | 1 | Width select to the ROM, 0 = byte |
| rom_ce_n | output | 1 | Chip select, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| rom_d_in | input | 16 | Data bus from the ROM |

## Verification
The case that needs the most care is the edge where recovery ends, because a held request is accepted on that same edge. That one edge must close the gap, re-launch the address and choose the shorter select-warm sample count. The bench keeps req_valid high through recovery so that reads chain directly, mixing byte and word modes. A behavioural ROM model returns valid data only after its own address, select and output-enable windows have expired, so a latch taken one cycle too early shows up as wrong data. A cycle model in the bench predicts the ready, select, enable and strobe levels on every clock and compares them with the outputs.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/1ps
package rom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ENABLE,
        ST_WAIT,
        ST_RECOVER
    } rd_state_e;

    // time in ps rounded up to whole clock cycles
    function automatic int unsigned to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // latch edge counted from the address launch; warm = select already active
    function automatic int unsigned samp_cyc(input int unsigned n_aa, input int unsigned n_ace,
                                             input int unsigned n_oe, input bit warm);
        int unsigned s;
        s = umax(n_aa, umax(n_oe + 1, 3));
        if (!warm) s = umax(s, n_ace);
        return s;
    endfunction

endpackage

// File: rtl/rom_rd_cnt.sv
`timescale 1ns/1ps
module rom_rd_cnt #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         en_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = W'(1);
        else if (en_i && (cnt_q != {W{1'b1}}))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q_o = cnt_q;
endmodule

// File: rtl/rom_rd_sched.sv
`timescale 1ns/1ps
module rom_rd_sched import rom_rd_pkg::*; #(
    parameter int unsigned N_AA   = 15,
    parameter int unsigned N_ACE  = 15,
    parameter int unsigned N_OE   = 7,
    parameter int unsigned N_RC   = 15,
    parameter int unsigned N_FLT  = 6,
    parameter bit          KEEP_CE = 1'b0,
    parameter int unsigned CNT_W  = 6
) (
    input  logic             warm_i,
    input  logic [CNT_W-1:0] cur_tgt_i,
    output logic [CNT_W-1:0] tgt_o,
    output logic [CNT_W-1:0] gap_o
);
    localparam int unsigned S_COLD = samp_cyc(N_AA, N_ACE, N_OE, 1'b0);
    localparam int unsigned S_WARM = samp_cyc(N_AA, N_ACE, N_OE, 1'b1);

    generate
        if (KEEP_CE) begin : g_warm
            assign tgt_o = warm_i ? CNT_W'(S_WARM) : CNT_W'(S_COLD);
        end else begin : g_cold
            logic unused_warm;
            assign unused_warm = warm_i;
            assign tgt_o = CNT_W'(S_COLD);
        end
    endgenerate

    logic [CNT_W-1:0] flt_end;
    assign flt_end = cur_tgt_i + CNT_W'(N_FLT);
    assign gap_o   = (flt_end > CNT_W'(N_RC)) ? flt_end : CNT_W'(N_RC);
endmodule

// File: rtl/rom_rd_lane.sv
`timescale 1ns/1ps
module rom_rd_lane (
    input  logic        byte_i,
    input  logic [15:0] d_i,
    output logic [15:0] data_o
);
    // byte reads: the ROM places the selected byte on the low lane
    assign data_o = byte_i ? {8'h00, d_i[7:0]} : d_i;
endmodule

// File: rtl/rom_rd_ctrl.sv
`timescale 1ns/1ps
module rom_rd_ctrl import rom_rd_pkg::*; #(
    parameter int unsigned ADDR_W    = 21,
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned T_AA_PS   = 150000,
    parameter int unsigned T_ACE_PS  = 150000,
    parameter int unsigned T_OE_PS   = 70000,
    parameter int unsigned T_RC_PS   = 150000,
    parameter int unsigned T_FLT_PS  = 60000,
    parameter bit          KEEP_CE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W:0]   req_addr,
    input  logic              req_byte,
    output logic              rsp_valid,
    output logic [15:0]       rsp_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_lsb_out,
    output logic              rom_lsb_oe,
    output logic              rom_byte_n,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [15:0]       rom_d_in
);
    localparam int unsigned N_AA   = to_cyc(T_AA_PS,  CLK_PS);
    localparam int unsigned N_ACE  = to_cyc(T_ACE_PS, CLK_PS);
    localparam int unsigned N_OE   = to_cyc(T_OE_PS,  CLK_PS);
    localparam int unsigned N_RC   = to_cyc(T_RC_PS,  CLK_PS);
    localparam int unsigned N_FLT  = to_cyc(T_FLT_PS, CLK_PS);
    localparam int unsigned S_MAX  = samp_cyc(N_AA, N_ACE, N_OE, 1'b0);
    localparam int unsigned G_MAX  = umax(N_RC, S_MAX + N_FLT);
    localparam int unsigned CNT_W  = $clog2(G_MAX + 2);

    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              lsb;
        logic              byte_m;
        logic              ce_n;
        logic              oe_n;
        logic [CNT_W-1:0]  tgt;
        logic              vld;
        logic [15:0]       data;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, addr: '0, lsb: 1'b0, byte_m: 1'b0, ce_n: 1'b1,
        oe_n: 1'b1, tgt: CNT_W'(3), vld: 1'b0, data: '0
    };

    regs_t            regs_d, regs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_new;
    logic [CNT_W-1:0] gap_end;
    logic [15:0]      cap_data;
    logic             warm;
    logic             gap_done;
    logic             ready;
    logic             accept;

    assign gap_done = (regs_q.st == ST_RECOVER) && (cnt_q >= gap_end);
    assign ready    = (regs_q.st == ST_IDLE) || gap_done;
    assign accept   = req_valid && ready;
    assign warm     = (regs_q.st == ST_RECOVER) && !regs_q.ce_n;

    rom_rd_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .en_i   (regs_q.st != ST_IDLE),
        .q_o    (cnt_q)
    );

    rom_rd_sched #(
        .N_AA(N_AA), .N_ACE(N_ACE), .N_OE(N_OE), .N_RC(N_RC),
        .N_FLT(N_FLT), .KEEP_CE(KEEP_CE), .CNT_W(CNT_W)
    ) u_sched (
        .warm_i    (warm),
        .cur_tgt_i (regs_q.tgt),
        .tgt_o     (tgt_new),
        .gap_o     (gap_end)
    );

    rom_rd_lane u_lane (
        .byte_i (regs_q.byte_m),
        .d_i    (rom_d_in),
        .data_o (cap_data)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.vld = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: ;
            ST_SETUP: begin
                regs_d.oe_n = 1'b0;
                regs_d.st   = ST_ENABLE;
            end
            ST_ENABLE: regs_d.st = ST_WAIT;
            ST_WAIT: begin
                if (cnt_q == regs_q.tgt) begin
                    regs_d.data = cap_data;
                    regs_d.vld  = 1'b1;
                    regs_d.oe_n = 1'b1;
                    regs_d.ce_n = !KEEP_CE;
                    regs_d.st   = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (gap_done) begin
                    regs_d.ce_n = 1'b1;
                    regs_d.st   = ST_IDLE;
                end
            end
            default: regs_d = REGS_RST;
        endcase
        if (accept) begin
            regs_d.st     = ST_SETUP;
            regs_d.addr   = req_addr[ADDR_W:1];
            regs_d.lsb    = req_addr[0];
            regs_d.byte_m = req_byte;
            regs_d.ce_n   = 1'b0;
            regs_d.oe_n   = 1'b1;
            regs_d.tgt    = tgt_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign req_ready   = ready;
    assign rsp_valid   = regs_q.vld;
    assign rsp_data    = regs_q.data;
    assign rom_addr    = regs_q.addr;
    assign rom_lsb_out = regs_q.lsb;
    assign rom_lsb_oe  = regs_q.byte_m;
    assign rom_byte_n  = !regs_q.byte_m;
    assign rom_ce_n    = regs_q.ce_n;
    assign rom_oe_n    = regs_q.oe_n;
endmodule

// File: rtl/rom_rd_chk.sv
`timescale 1ns/1ps
module rom_rd_chk #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned N_RC   = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [15:0]       rsp_data,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_lsb_out,
    input logic              rom_byte_n,
    input logic              rom_ce_n,
    input logic              rom_oe_n
);
    localparam int unsigned AGE_W = $clog2(N_RC + 1) + 1;
    logic [AGE_W-1:0] age_q;

    // edges since the last accepted request, saturating at the cycle time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      age_q <= AGE_W'(N_RC);
        else if (req_valid && req_ready) age_q <= AGE_W'(1);
        else if (age_q < AGE_W'(N_RC))   age_q <= age_q + AGE_W'(1);
    end

    // R11
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> ($stable(rom_addr) && $stable(rom_lsb_out)));

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rom_oe_n && $past(!rom_oe_n)));

    // R7
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !req_ready);

    // R7
    cycle_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (age_q >= AGE_W'(N_RC)));

    // R3
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rom_byte_n) |-> (rsp_data[15:8] == 8'h00));
endmodule

bind rom_rd_ctrl rom_rd_chk #(.ADDR_W(ADDR_W), .N_RC(N_RC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rom_addr    (rom_addr),
    .rom_lsb_out (rom_lsb_out),
    .rom_byte_n  (rom_byte_n),
    .rom_ce_n    (rom_ce_n),
    .rom_oe_n    (rom_oe_n)
);

// File: tb/sim_rom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_rom_rd_ctrl;
    localparam int CLK_NS  = 10;
    localparam int AW      = 21;
    localparam int P_CLK   = 10000;
    localparam int P_AA    = 115000;
    localparam int P_ACE   = 150000;
    localparam int P_OE    = 65000;
    localparam int P_RC    = 150000;
    localparam int P_FLT   = 60000;

    // bench's own cycle arithmetic, from the requirements
    localparam int C_AA   = (P_AA  + P_CLK - 1) / P_CLK;   // 12
    localparam int C_ACE  = (P_ACE + P_CLK - 1) / P_CLK;   // 15
    localparam int C_OE   = (P_OE  + P_CLK - 1) / P_CLK;   // 7
    localparam int C_RC   = (P_RC  + P_CLK - 1) / P_CLK;   // 15
    localparam int C_FLT  = (P_FLT + P_CLK - 1) / P_CLK;   // 6

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW:0]   req_addr = '0;
    logic          req_byte = 1'b0;
    logic          rsp_valid;
    logic [15:0]   rsp_data;
    logic [AW-1:0] rom_addr;
    logic          rom_lsb_out, rom_lsb_oe, rom_byte_n, rom_ce_n, rom_oe_n;
    logic [15:0]   rom_d_in = 16'hE1E1;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    rom_rd_ctrl #(
        .ADDR_W(AW), .CLK_PS(P_CLK), .T_AA_PS(P_AA), .T_ACE_PS(P_ACE),
        .T_OE_PS(P_OE), .T_RC_PS(P_RC), .T_FLT_PS(P_FLT), .KEEP_CE(1'b1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_lsb_out(rom_lsb_out),
        .rom_lsb_oe(rom_lsb_oe), .rom_byte_n(rom_byte_n), .rom_ce_n(rom_ce_n),
        .rom_oe_n(rom_oe_n), .rom_d_in(rom_d_in)
    );

    function automatic logic [15:0] rom_word(input logic [AW-1:0] a);
        return (a[15:0] ^ {a[20:16], 11'h5A3}) + 16'h1F0F;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // reference model
    bit          m_busy = 0;
    int          m_j = 0, m_tgt = 0, m_gap = 0;
    logic [AW:0] m_addr = '0;
    bit          m_byte = 0;
    logic [15:0] m_data = '0;
    bit          acc_seen = 0;
    bit          run = 0;
    int          cyc = 0;
    bit          wd_hit = 0;
    // ROM model ages (negedges since event)
    int          a_age = 0, ce_age = -1, oe_age = -1;
    logic [AW:0] last_a = '0;

    always @(negedge clk) begin
        if (run) begin
            bit e_rdy, e_ce, e_oe, e_vld;
            cyc++;
            if (!m_busy) begin
                e_rdy = 1; e_ce = 1; e_oe = 1; e_vld = 0;
            end else begin
                e_ce  = (m_j < m_tgt) ? 1'b0 : 1'b0; // KEEP_CE holds select low in recovery
                e_oe  = (m_j >= 1 && m_j < m_tgt) ? 1'b0 : 1'b1;
                e_vld = (m_j == m_tgt);
                e_rdy = (m_j >= m_gap - 1);
            end
            chk((m_busy && req_valid) ? "R8 ready" : "R7 ready", {31'd0, req_ready}, {31'd0, e_rdy});
            chk(m_busy ? "R9 ce" : "R10 ce", {31'd0, rom_ce_n}, {31'd0, e_ce});
            chk((m_busy && m_j == 0) ? "R2 oe" : "R6 oe", {31'd0, rom_oe_n}, {31'd0, e_oe});
            chk("R5 strobe", {31'd0, rsp_valid}, {31'd0, e_vld});
            chk("R11 oe/ce", {31'd0, (!rom_oe_n && rom_ce_n)}, 32'd0);
            if (e_vld)
                chk(m_byte ? "R3 data" : "R4 data", {16'd0, rsp_data}, {16'd0, m_data});
            if (m_busy && m_j == 0) begin
                chk("R2 addr", {11'd0, rom_addr}, {11'd0, m_addr[AW:1]});
                chk(m_byte ? "R3 width pin" : "R4 width pin", {31'd0, rom_byte_n}, {31'd0, !m_byte});
                chk(m_byte ? "R3 lsb drive" : "R4 lsb drive", {31'd0, rom_lsb_oe}, {31'd0, m_byte});
                if (m_byte) chk("R3 lsb value", {31'd0, rom_lsb_out}, {31'd0, m_addr[0]});
            end

            // ROM model
            if ({rom_addr, rom_lsb_out} != last_a) a_age = 0; else a_age++;
            last_a = {rom_addr, rom_lsb_out};
            if (rom_ce_n) ce_age = -1; else ce_age++;
            if (rom_oe_n) oe_age = -1; else oe_age++;
            if (a_age >= C_AA - 1 && ce_age >= C_ACE - 1 && oe_age >= C_OE - 1) begin
                logic [15:0] w;
                w = rom_word(rom_addr);
                if (!rom_byte_n) rom_d_in = {8'hA5, rom_lsb_out ? w[15:8] : w[7:0]};
                else             rom_d_in = w;
            end else
                rom_d_in = 16'hE1E1;

            // model step toward the next edge
            if (req_valid && e_rdy) begin
                logic [15:0] w;
                bit warm;
                warm   = m_busy;
                m_busy = 1;
                m_j    = 0;
                m_tgt  = warm ? mx(C_AA, mx(C_OE + 1, 3)) : mx(mx(C_AA, C_ACE), mx(C_OE + 1, 3));
                m_gap  = mx(C_RC, m_tgt + C_FLT);
                m_addr = req_addr;
                m_byte = req_byte;
                w      = rom_word(req_addr[AW:1]);
                m_data = req_byte ? {8'h00, req_addr[0] ? w[15:8] : w[7:0]} : w;
                acc_seen = 1;
            end else if (m_busy) begin
                if (m_j >= m_gap - 1) m_busy = 0;
                else m_j++;
            end
            if (cyc > 3000 && !wd_hit) begin
                wd_hit = 1;
                errors++;
                $display("FAIL watchdog actual=running expected=done");
            end
        end
    end

    task automatic do_req(input logic [AW:0] a, input bit b);
        req_valid = 1'b1;
        req_addr  = a;
        req_byte  = b;
        forever begin
            @(posedge clk);
            if (acc_seen || wd_hit) break;
        end
        acc_seen = 0;
        #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_NS/2 + 1);
        // R1 reset state
        chk("R1 ready",  {31'd0, req_ready},  32'd1);
        chk("R1 ce",     {31'd0, rom_ce_n},   32'd1);
        chk("R1 oe",     {31'd0, rom_oe_n},   32'd1);
        chk("R1 strobe", {31'd0, rsp_valid},  32'd0);
        chk("R1 width",  {31'd0, rom_byte_n}, 32'd1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run   = 1;
        idle(3);
        // cold word read, then return to idle (R5, R10)
        do_req(22'h00ABC4, 1'b0);
        idle(30);
        // byte reads of both halves (R3)
        do_req(22'h12346, 1'b1);
        idle(30);
        // chained reads held through recovery (R8, R9)
        do_req(22'h12347, 1'b1);
        do_req(22'h3FFFFF, 1'b0);
        do_req(22'h000001, 1'b1);
        idle(30);
        // word read with odd byte address, bit 0 ignored (R4)
        do_req(22'h2AAAA7, 1'b0);
        do_req(22'h155554, 1'b0);
        idle(30);
        run = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule